// File: doc/BRIEF.md
# Clock Calendar Update Engine

This block keeps the time of day and the calendar for a real-time clock. A strobe at the 32.768 kHz time-base rate drives a divider. Once per second the divider starts an update cycle. That cycle advances seconds, minutes, hours, day of week, day of month, month and year in one step, and it honours month lengths and leap years. When enabled, the cycle also applies the spring-forward and fall-back daylight-saving jumps.

The engine holds two copies of the time. The local copy advances on every update. The user copy, which the host sees, is refreshed from the update only while transfers are allowed, so the host can freeze a coherent snapshot to read. Values are held internally in binary. They are encoded for the host in BCD or binary, with a 24-hour or 12-hour (PM flag) hours byte. Host writes are decoded with the same settings.

An update-in-progress flag warns the host a fixed lead time before each update. A one-cycle completion pulse marks the end of the update. A century flag follows the last year value the host wrote.

Top module: `rtc_cal_engine`

## Requirements
- R1: The divider runs only while osc_ctl is 3'b010 or 3'b011. When it starts from the stopped state, the first update happens TICKS_PER_SEC/2 ticks later.
- R2: While the divider runs, one update happens every TICKS_PER_SEC ticks. Each update raises upd_done for exactly one clock.
- R3: With any other osc_ctl value (including 3'b110 and 3'b111), the divider holds at its half-second point. No update happens and uip stays low.
- R4: uip goes high LEAD_TICKS ticks before each update and is low in the cycle where upd_done pulses.
- R5: While xfer_inhibit is 1, the user copy does not change on updates, the local copy keeps advancing, and uip stays low. After xfer_inhibit returns to 0, the next update shows the advanced local time.
- R6: When fmt_bin is 1, every time byte on the outputs and on wr_data is plain binary. When fmt_bin is 0, every such byte is two-digit BCD (tens in bits 7:4).
- R7: When hr_24 is 1, the hours byte is 0-23. When hr_24 is 0, it is 1-12, with bit 7 set for PM, so midnight reads 12 and noon reads 12 with bit 7 set.
- R8: Seconds and minutes wrap at 60, and hours wrap at 24. Day of week runs 1-7, with 7 followed by 1. Day of month wraps after 30 days in April, June, September and November, after 29 days in February when year mod 4 is 0, after 28 days in any other February, and after 31 days otherwise. Month 12 wraps to 1, and year 99 wraps to 0.
- R9: When dst_en is 1, on a Sunday (day of week 1) in April with day of month at most 7, the update after 01:59:59 gives 03:00:00.
- R10: When dst_en is 1, on a Sunday in October with day of month at least 25, the first update after 01:59:59 gives 01:00:00. Later passes of 01:59:59 before the next midnight continue to 02:00:00.
- R11: A write with wr_en loads one field into both copies on the next clock, using field codes 0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month and 6 year. The written value is the base for the next update. Code 7 changes nothing.
- R12: Writing the year sets century to 1 when the written year is 80-99 and to 0 when it is 0-79. Updates leave century unchanged.
- R13: After reset, the time is 00:00:00, day of week 1, day 1, month 1 and year 0. Century, uip and upd_done are 0, and the divider is at its half-second point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle strobe at the time-base rate |
| osc_ctl | input | 3 | Oscillator and divider control field |
| fmt_bin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr_24 | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables daylight-saving jumps |
| xfer_inhibit | input | 1 | Freezes the user copy and holds uip low |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field code of the write |
| wr_data | input | 8 | Encoded field value |
| usr_sec | output | 8 | User copy, seconds |
| usr_min | output | 8 | User copy, minutes |
| usr_hour | output | 8 | User copy, hours |
| usr_dow | output | 8 | User copy, day of week |
| usr_dom | output | 8 | User copy, day of month |
| usr_mon | output | 8 | User copy, month |
| usr_year | output | 8 | User copy, year |
| century | output | 1 | Century flag from the last year write |
| uip | output | 1 | Update-in-progress warning |
| upd_done | output | 1 | One-cycle update-complete pulse |

## Verification
The bench goes after the carry chain at its longest: 23:59:59 on the last day of December 99, February in leap and common years, and 30-day months. A design with a wrong month-length or carry rule would show a day 31 in April or skip February 29.

It measures, in cycles, the half-second first update and the lead of uip. An off-by-one divider would move either of them by a tick.

The bench checks both daylight-saving jumps, including a second pass through 01:59:59 on the fall-back day. A design without the once-only flag would loop back to 01:00:00 forever. The inhibit sequence writes a field while the user copy is frozen, then releases the freeze. A design that advanced the user copy, or that dropped the write from the local copy, would show a wrong minute after the release.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NFIELD = 7;

  // Field order fixes the index used by host writes: 0 sec ... 6 year.
  typedef struct packed {
    logic [6:0] year;
    logic [6:0] mon;
    logic [6:0] dom;
    logic [6:0] dow;
    logic [6:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  typedef logic [NFIELD-1:0][6:0] cal_arr_t;

  function automatic logic [7:0] enc_byte(logic [6:0] v, logic bin);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] dec_byte(logic [7:0] b, logic bin);
    return bin ? b[6:0] : ({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
  endfunction

  function automatic logic [7:0] enc_hour(logic [6:0] h, logic bin, logic h24);
    logic [6:0] h12;
    logic       pm;
    logic [7:0] e;
    if (h24) return enc_byte(h, bin);
    pm  = (h >= 7'd12);
    h12 = pm ? h - 7'd12 : h;
    if (h12 == 7'd0) h12 = 7'd12;
    e = enc_byte(h12, bin);
    return {pm, e[6:0]};
  endfunction

  function automatic logic [6:0] dec_hour(logic [7:0] b, logic bin, logic h24);
    logic [6:0] h;
    if (h24) return dec_byte(b, bin);
    h = dec_byte({1'b0, b[6:0]}, bin);
    if (h == 7'd12) h = 7'd0;
    if (b[7]) h = h + 7'd12;
    return h;
  endfunction

  function automatic logic [6:0] days_in_month(logic [6:0] mon, logic [6:0] year);
    case (mon)
      7'd2:                       return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

  function automatic logic at_0159_sunday(cal_t t);
    return (t.dow == 7'd1) && (t.hour == 7'd1) && (t.min == 7'd59) && (t.sec == 7'd59);
  endfunction

  function automatic logic spring_due(cal_t t, logic en);
    return en && at_0159_sunday(t) && (t.mon == 7'd4) && (t.dom <= 7'd7);
  endfunction

  function automatic logic fall_due(cal_t t, logic en, logic done);
    return en && !done && at_0159_sunday(t) && (t.mon == 7'd10) && (t.dom >= 7'd25);
  endfunction

  function automatic logic day_rolls(cal_t t);
    return (t.hour == 7'd23) && (t.min == 7'd59) && (t.sec == 7'd59);
  endfunction

  function automatic cal_t advance(cal_t t, logic spring, logic fall);
    cal_t n;
    n = t;
    if (t.sec != 7'd59) n.sec = t.sec + 7'd1;
    else begin
      n.sec = 7'd0;
      if (t.min != 7'd59) n.min = t.min + 7'd1;
      else begin
        n.min = 7'd0;
        if (spring)              n.hour = 7'd3;
        else if (fall)           n.hour = 7'd1;
        else if (t.hour != 7'd23) n.hour = t.hour + 7'd1;
        else begin
          n.hour = 7'd0;
          n.dow  = (t.dow >= 7'd7) ? 7'd1 : t.dow + 7'd1;
          if (t.dom >= days_in_month(t.mon, t.year)) begin
            n.dom = 7'd1;
            if (t.mon >= 7'd12) begin
              n.mon  = 7'd1;
              n.year = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
            end else n.mon = t.mon + 7'd1;
          end else n.dom = t.dom + 7'd1;
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_en,
  input  logic inhibit,
  output logic upd_stb,
  output logic uip,
  output logic upd_done
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF    = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] LEAD_AT = CW'(TICKS_PER_SEC - LEAD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;

  assign upd_stb = run_en && tick && (cnt_q == LAST);

  always_comb begin
    if (!run_en)      cnt_d = HALF;
    else if (upd_stb) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + CW'(1);
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= HALF;
      uip      <= 1'b0;
      upd_done <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      uip      <= run_en && !inhibit && (cnt_d >= LEAD_AT);
      upd_done <= upd_stb;
    end
  end

  // R4: a running, uninhibited divider has warned before the update fires
  p_uip_before_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && $past(run_en) && !$past(inhibit)) |-> uip);

  // R4: the warning is gone when completion is signalled
  p_done_clears_uip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !uip);

  // R5: inhibit keeps the warning low
  p_uip_off_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !uip);

endmodule

// File: rtl/rtc_field_out.sv
module rtc_field_out
  import rtc_cal_pkg::*;
#(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [6:0] val,
  input  logic       bin,
  input  logic       h24,
  output logic [7:0] code
);
  generate
    if (IS_HOUR) begin : g_hour
      assign code = enc_hour(val, bin, h24);
    end else begin : g_plain
      logic unused_h24;
      assign unused_h24 = h24;
      assign code = enc_byte(val, bin);
    end
  endgenerate
endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int LEAD_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [2:0] osc_ctl,
  input  logic       fmt_bin,
  input  logic       hr_24,
  input  logic       dst_en,
  input  logic       xfer_inhibit,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] usr_sec,
  output logic [7:0] usr_min,
  output logic [7:0] usr_hour,
  output logic [7:0] usr_dow,
  output logic [7:0] usr_dom,
  output logic [7:0] usr_mon,
  output logic [7:0] usr_year,
  output logic       century,
  output logic       uip,
  output logic       upd_done
);
  localparam int  HOUR_IDX = 2;
  localparam int  YEAR_IDX = 6;
  localparam cal_arr_t CAL_RESET = {7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0, 7'd0};

  cal_arr_t   loc_q, loc_d, usr_q, usr_d;
  cal_t       adv;
  logic       fell_q, fell_d, cent_q;
  logic       run_en, upd_stb, spring, fall;
  logic [6:0] wr_val;
  logic [7:0] code_b [NFIELD];

  assign run_en = (osc_ctl[2:1] == 2'b01);

  rtc_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC), .LEAD_TICKS(LEAD_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .run_en(run_en), .inhibit(xfer_inhibit),
    .upd_stb(upd_stb), .uip(uip), .upd_done(upd_done)
  );

  assign spring = spring_due(loc_q, dst_en);
  assign fall   = fall_due(loc_q, dst_en, fell_q);
  assign adv    = advance(loc_q, spring, fall);
  assign wr_val = (wr_sel == 3'(HOUR_IDX)) ? dec_hour(wr_data, fmt_bin, hr_24)
                                           : dec_byte(wr_data, fmt_bin);

  always_comb begin
    loc_d  = upd_stb ? adv : loc_q;
    usr_d  = (upd_stb && !xfer_inhibit) ? adv : usr_q;
    fell_d = fell_q;
    if (upd_stb) begin
      if (fall)                  fell_d = 1'b1;
      else if (day_rolls(loc_q)) fell_d = 1'b0;
    end
    for (int i = 0; i < NFIELD; i++) begin
      if (wr_en && (wr_sel == 3'(i))) begin
        loc_d[i] = wr_val;
        usr_d[i] = wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_q  <= CAL_RESET;
      usr_q  <= CAL_RESET;
      fell_q <= 1'b0;
      cent_q <= 1'b0;
    end else begin
      loc_q  <= loc_d;
      usr_q  <= usr_d;
      fell_q <= fell_d;
      if (wr_en && (wr_sel == 3'(YEAR_IDX))) cent_q <= (wr_val >= 7'd80);
    end
  end

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_out
      rtc_field_out #(.IS_HOUR(g == HOUR_IDX)) u_fo (
        .val(usr_q[g]), .bin(fmt_bin), .h24(hr_24), .code(code_b[g])
      );
    end
  endgenerate

  assign usr_sec  = code_b[0];
  assign usr_min  = code_b[1];
  assign usr_hour = code_b[2];
  assign usr_dow  = code_b[3];
  assign usr_dom  = code_b[4];
  assign usr_mon  = code_b[5];
  assign usr_year = code_b[6];
  assign century  = cent_q;

  // R5: frozen user copy while transfers are inhibited and no host write arrives
  p_user_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_inhibit && !wr_en) |=> $stable(usr_q));

  // R9: spring-forward lands on three o'clock
  p_spring_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && spring && !wr_en) |=> (loc_q[HOUR_IDX] == 7'd3));

  // R10: fall-back lands on one o'clock and is remembered
  p_fall_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && fall && !wr_en) |=> (fell_q && loc_q[HOUR_IDX] == 7'd1));

endmodule

// File: tb/rtc_cal_engine_test.sv
module rtc_cal_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 64;
  localparam int LEAD       = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b1;
  logic [2:0] osc_ctl = 3'b000, wr_sel = 3'd0;
  logic fmt_bin = 1'b0, hr_24 = 1'b1, dst_en = 1'b0, xfer_inhibit = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] usr_sec, usr_min, usr_hour, usr_dow, usr_dom, usr_mon, usr_year;
  logic century, uip, upd_done;

  int total = 0, bad = 0;
  int r_s = 0, r_m = 0, r_h = 0, r_dw = 1, r_dm = 1, r_mo = 1, r_yr = 0;
  bit r_fell = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_cal_engine #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .osc_ctl(osc_ctl), .fmt_bin(fmt_bin),
    .hr_24(hr_24), .dst_en(dst_en), .xfer_inhibit(xfer_inhibit), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .usr_sec(usr_sec), .usr_min(usr_min),
    .usr_hour(usr_hour), .usr_dow(usr_dow), .usr_dom(usr_dom), .usr_mon(usr_mon),
    .usr_year(usr_year), .century(century), .uip(uip), .upd_done(upd_done)
  );

  function automatic logic [7:0] tb_enc(int v, bit bin);
    return bin ? 8'(v) : 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] tb_hour(int h, bit bin, bit h24);
    int h12;
    logic [7:0] b;
    if (h24) return tb_enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    b = tb_enc(h12, bin);
    if (h >= 12) b[7] = 1'b1;
    return b;
  endfunction

  function automatic int tb_dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic ref_step();
    bit fwd, back;
    fwd  = dst_en && r_dw == 1 && r_mo == 4 && r_dm < 8 && r_h == 1 && r_m == 59 && r_s == 59;
    back = dst_en && !r_fell && r_dw == 1 && r_mo == 10 && r_dm > 24 && r_h == 1 && r_m == 59 && r_s == 59;
    r_s++;
    if (r_s == 60) begin r_s = 0; r_m++; end
    if (r_m == 60) begin r_m = 0; r_h++; end
    if (fwd) r_h = 3;
    if (back) begin r_h = 1; r_fell = 1'b1; end
    if (r_h == 24) begin r_h = 0; r_fell = 1'b0; r_dw = r_dw % 7 + 1; r_dm++; end
    if (r_dm > tb_dim(r_mo, r_yr)) begin r_dm = 1; r_mo++; end
    if (r_mo == 13) begin r_mo = 1; r_yr = (r_yr + 1) % 100; end
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_time(string tag);
    check({tag, " sec"},  usr_sec,  tb_enc(r_s, fmt_bin));
    check({tag, " min"},  usr_min,  tb_enc(r_m, fmt_bin));
    check({tag, " hour"}, usr_hour, tb_hour(r_h, fmt_bin, hr_24));
    check({tag, " dow"},  usr_dow,  tb_enc(r_dw, fmt_bin));
    check({tag, " dom"},  usr_dom,  tb_enc(r_dm, fmt_bin));
    check({tag, " mon"},  usr_mon,  tb_enc(r_mo, fmt_bin));
    check({tag, " year"}, usr_year, tb_enc(r_yr, fmt_bin));
  endtask

  task automatic wait_upd(output int cyc, output int uip_at);
    cyc = 0;
    uip_at = -1;
    do begin
      @(negedge clk);
      cyc++;
      if (uip && uip_at < 0) uip_at = cyc;
    end while (!upd_done && cyc < 4 * TPS);
    if (!upd_done) begin
      total++; bad++;
      $display("FAIL R2: no update after %0d cycles (expected one)", cyc);
    end
  endtask

  task automatic step_check(string tag);
    int cyc, ua;
    wait_upd(cyc, ua);
    ref_step();
    check_time(tag);
  endtask

  task automatic wr_field(int sel, logic [7:0] d);
    wr_sel = 3'(sel); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int h, int m, int s, int dw, int dm, int mo, int yr);
    osc_ctl = 3'b000;
    @(negedge clk);
    wr_field(0, tb_enc(s, fmt_bin));
    wr_field(1, tb_enc(m, fmt_bin));
    wr_field(2, tb_hour(h, fmt_bin, hr_24));
    wr_field(3, tb_enc(dw, fmt_bin));
    wr_field(4, tb_enc(dm, fmt_bin));
    wr_field(5, tb_enc(mo, fmt_bin));
    wr_field(6, tb_enc(yr, fmt_bin));
    r_h = h; r_m = m; r_s = s; r_dw = dw; r_dm = dm; r_mo = mo; r_yr = yr;
    osc_ctl = 3'b010;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, ua, n;
    logic [7:0] snap [7];
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check_time("R13 reset");
    check("R13 century", {7'b0, century}, 8'h00);
    check("R13 uip", {7'b0, uip}, 8'h00);
    check("R13 upd_done", {7'b0, upd_done}, 8'h00);
    hr_24 = 1'b0; #1;
    check("R7 midnight 12h", usr_hour, 8'h12);
    hr_24 = 1'b1;

    // R3 stopped divider
    n = 0;
    osc_ctl = 3'b110;
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk);
      if (upd_done || uip) n++;
    end
    check("R3 no update when stopped", 8'(n), 8'd0);

    // R1 / R4 first update after start
    osc_ctl = 3'b010;
    wait_upd(cyc, ua);
    check("R1 first update delay", 8'(cyc), 8'(TPS / 2));
    check("R4 uip lead (first)", 8'(ua), 8'(TPS / 2 - LEAD));
    check("R4 uip low at done", {7'b0, uip}, 8'h00);
    ref_step();
    check_time("R1 first update");

    // R2 steady period, code 011 also runs
    osc_ctl = 3'b011;
    wait_upd(cyc, ua);
    check("R2 period", 8'(cyc), 8'(TPS));
    check("R4 uip lead", 8'(ua), 8'(TPS - LEAD));
    ref_step();
    check_time("R2 second update");
    @(negedge clk);
    check("R2 done is one cycle", {7'b0, upd_done}, 8'h00);

    // R8 long carry chain
    load(23, 59, 58, 7, 31, 12, 99);
    repeat (2) step_check("R8 year wrap");
    load(23, 59, 59, 3, 28, 2, 24);
    step_check("R8 leap february");
    load(23, 59, 59, 3, 28, 2, 23);
    step_check("R8 common february");
    load(23, 59, 59, 5, 30, 4, 10);
    step_check("R8 thirty-day month");

    // R6 / R7 encodings
    fmt_bin = 1'b1; hr_24 = 1'b0;
    load(11, 59, 59, 2, 5, 6, 7);
    step_check("R7 noon binary");
    check("R7 noon binary byte", usr_hour, 8'h8C);
    load(23, 59, 59, 2, 5, 6, 7);
    step_check("R6 midnight binary");
    fmt_bin = 1'b0;
    load(12, 59, 59, 2, 5, 6, 7);
    step_check("R7 1pm bcd");
    check("R7 1pm bcd byte", usr_hour, 8'h81);
    hr_24 = 1'b1;
    load(19, 45, 59, 4, 17, 9, 45);
    step_check("R6 bcd 24h");
    check("R6 bcd minute byte", usr_min, 8'h46);

    // R11 write visibility and ignored code 7
    osc_ctl = 3'b000;
    @(negedge clk);
    wr_field(0, 8'h42);
    check("R11 immediate write", usr_sec, 8'h42);
    r_s = 42;
    for (int i = 0; i < 7; i++) begin
      snap[i] = (i == 0) ? usr_sec : (i == 1) ? usr_min : (i == 2) ? usr_hour :
                (i == 3) ? usr_dow : (i == 4) ? usr_dom : (i == 5) ? usr_mon : usr_year;
    end
    wr_field(7, 8'h33);
    check_time("R11 code 7 ignored");
    osc_ctl = 3'b010;
    step_check("R11 update from written value");

    // R12 century
    wr_field(6, 8'h85); r_yr = 85;
    check("R12 year 85", {7'b0, century}, 8'h01);
    wr_field(6, 8'h79); r_yr = 79;
    check("R12 year 79", {7'b0, century}, 8'h00);
    wr_field(6, 8'h80); r_yr = 80;
    check("R12 year 80", {7'b0, century}, 8'h01);
    step_check("R12 after year writes");
    check("R12 kept by update", {7'b0, century}, 8'h01);

    // R5 inhibit, with a write while frozen (R11 local copy)
    load(10, 20, 30, 3, 9, 3, 50);
    step_check("R5 before inhibit");
    xfer_inhibit = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      snap[i] = (i == 0) ? usr_sec : (i == 1) ? usr_min : (i == 2) ? usr_hour :
                (i == 3) ? usr_dow : (i == 4) ? usr_dom : (i == 5) ? usr_mon : usr_year;
    end
    repeat (2) begin
      wait_upd(cyc, ua);
      ref_step();
      check("R5 frozen sec", usr_sec, snap[0]);
      check("R5 frozen min", usr_min, snap[1]);
      check("R5 uip held low", 8'(ua), 8'hFF);
    end
    wr_field(1, 8'h30); r_m = 30;
    check("R11 write while frozen", usr_min, 8'h30);
    wait_upd(cyc, ua);
    ref_step();
    check("R5 frozen after write", usr_sec, snap[0]);
    @(negedge clk);
    xfer_inhibit = 1'b0;
    step_check("R5 release shows local");

    // R9 spring forward
    dst_en = 1'b1;
    load(1, 59, 59, 1, 3, 4, 22);
    step_check("R9 spring sunday");
    check("R9 hour is 3", usr_hour, 8'h03);
    load(1, 59, 59, 2, 3, 4, 22);
    step_check("R9 weekday no jump");

    // R10 fall back once
    load(1, 59, 59, 1, 28, 10, 23);
    step_check("R10 fall back");
    check("R10 hour is 1", usr_hour, 8'h01);
    osc_ctl = 3'b000;
    @(negedge clk);
    wr_field(1, 8'h59); wr_field(0, 8'h58);
    r_m = 59; r_s = 58;
    osc_ctl = 3'b010;
    repeat (2) step_check("R10 second pass");
    check("R10 hour is 2", usr_hour, 8'h02);
    dst_en = 1'b0;

    // Random mix of formats and dates (R6 R7 R8)
    for (int it = 0; it < 40; it++) begin
      int mo, yr, dm, dw, h, m, s;
      fmt_bin = 1'($urandom % 2);
      hr_24   = 1'($urandom % 2);
      mo = 1 + $urandom % 12;
      yr = $urandom % 100;
      dm = ($urandom % 3 == 0) ? tb_dim(mo, yr) : 1 + $urandom % tb_dim(mo, yr);
      dw = 1 + $urandom % 7;
      h  = ($urandom % 3 == 0) ? 23 : $urandom % 24;
      m  = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      s  = 57 + $urandom % 3;
      load(h, m, s, dw, dm, mo, yr);
      repeat (3) step_check("R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule